// File: doc/BRIEF.md
# Direct-Mapped Data Cache Controller with Selectable Write Policy

The block places a small direct-mapped data cache between a processor that issues single-word reads and writes and a slower memory that answers one word per request. A static input selects the write policy. In write-through mode every processor write goes to memory as well as to the cache. In copy-back mode a write touches only the cache and marks its line dirty. The dirty line reaches memory when it is evicted or when the cache is flushed. Write misses allocate: the line is fetched first and the write is then applied to it.

Requests whose address lies in a fixed uncacheable window, such as peripheral registers, skip the cache. They become one memory access each and never allocate a line. A flush command empties the cache. Under write-through it only drops the valid bits. Under copy-back it walks the lines in index order, writes back the dirty ones and invalidates each. The processor is held off on any miss, eviction, uncached access or write-through write, and gets a hit answer in the cycle of its request.

Top module: `dm_cache_ctl`

## Requirements
- R1: After reset every line is invalid and no line is dirty. The first access to any cacheable address misses, and `cpu_ready`, `mem_req` and `flush_done` are low.
- R2: A cacheable read that hits raises `cpu_ready` with the data in the same cycle as `cpu_req`, with no memory traffic.
- R3: A cacheable read miss fetches the whole 4-word line as consecutive memory reads. The reads run from word offset 0 upward in steps of 4 bytes, the line being picked by address bits [6:4] with the tag in bits [15:7]. The requested word is then returned.
- R4: An address whose bits [15:12] equal 4'hF is uncacheable. Each such access makes exactly one memory access with the processor's address and direction, and no line is allocated.
- R5: A cacheable write miss first fetches the line (4 reads) and then applies the write to it, so later reads of that line hit and see the new word.
- R6: With `copy_back` low, every cacheable write makes exactly one memory write of that word, and `cpu_ready` rises in the cycle of that write's `mem_ack`.
- R7: With `copy_back` high, a cacheable write hit completes in its request cycle with no memory traffic, and memory keeps its old value.
- R8: With `copy_back` high, a miss whose line is valid and dirty first writes the 4 old words back at the old address in ascending order, then fetches the new line. A clean victim causes no write-back.
- R9: With `copy_back` low, a flush pulse accepted while idle invalidates all lines with no memory traffic. `flush_done` is high in the following cycle.
- R10: With `copy_back` high, a flush writes back each dirty line in ascending index order (4 words each), skips clean lines, invalidates all lines and then pulses `flush_done`.
- R11: `cpu_ready` is only high while `cpu_req` is high. A memory request holds its address and direction stable until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| copy_back | input | 1 | Write policy: 1 copy-back, 0 write-through (static) |
| cpu_req | input | 1 | Processor request, held until cpu_ready |
| cpu_we | input | 1 | Processor write (1) or read (0) |
| cpu_addr | input | 16 | Processor byte address |
| cpu_wdata | input | 32 | Processor write data |
| cpu_rdata | output | 32 | Read data, valid with cpu_ready |
| cpu_ready | output | 1 | Request completes this cycle |
| flush_req | input | 1 | One-cycle flush command |
| flush_done | output | 1 | One-cycle pulse when the flush finishes |
| mem_req | output | 1 | Memory word request, held until mem_ack |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory word access completes this cycle |

## Verification
Some properties are checked on every cycle: the handshake rules on both ports, the one-word step between consecutive line-fill or write-back accesses, and the direct pass-through of uncached accesses. Also checked every cycle: a write-through write completes only with its memory write acknowledged, and a copy-back write hit completes with the memory port quiet. Data correctness depends on history, so only the directed scenarios can show it. This covers the ordering of a dirty eviction before its refill, the absence of write-back for clean victims, and which lines a copy-back flush writes and in what order. The scenarios also show that lines are really invalid after reset and after a flush.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
   timeunit 1ns;
   timeprecision 1ps;

   // Controller sequencing states
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,  // hits served here, new work accepted
      ST_BYP   = 3'd1,  // single uncached memory access
      ST_WT    = 3'd2,  // write-through word write
      ST_EVICT = 3'd3,  // dirty victim line write-back
      ST_FILL  = 3'd4,  // line refill burst
      ST_FSCAN = 3'd5,  // flush: inspect one line
      ST_FWB   = 3'd6   // flush: write back one dirty line
   } dmc_state_e;

endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
   parameter int LINES = 8,
   parameter int TAG_W = 9,
   localparam int IDX_W = $clog2(LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] idx,
   input  logic             fill,
   input  logic [TAG_W-1:0] fill_tag,
   input  logic             set_dirty,
   input  logic             clean,
   input  logic             inval,
   input  logic             inval_all,
   output logic             line_valid,
   output logic             line_dirty,
   output logic [TAG_W-1:0] line_tag
);
   timeunit 1ns;
   timeprecision 1ps;

   logic [LINES-1:0] valid_v;
   logic [LINES-1:0] dirty_v;
   logic [TAG_W-1:0] tag_v [LINES];

   for (genvar g = 0; g < LINES; g++) begin : g_line
      logic             sel;
      logic             v_q;
      logic             d_q;
      logic [TAG_W-1:0] t_q;

      assign sel = (idx == IDX_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q <= 1'b0;
            d_q <= 1'b0;
            t_q <= '0;
         end else if (inval_all || (inval && sel)) begin
            v_q <= 1'b0;
            d_q <= 1'b0;
         end else if (fill && sel) begin
            v_q <= 1'b1;
            d_q <= 1'b0;
            t_q <= fill_tag;
         end else if (set_dirty && sel) begin
            d_q <= 1'b1;
         end else if (clean && sel) begin
            d_q <= 1'b0;
         end
      end

      assign valid_v[g] = v_q;
      assign dirty_v[g] = d_q;
      assign tag_v[g]   = t_q;
   end

   assign line_valid = valid_v[idx];
   assign line_dirty = dirty_v[idx];
   assign line_tag   = tag_v[idx];

endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
   parameter int LINES  = 8,
   parameter int WORDS  = 4,
   parameter int DATA_W = 32,
   localparam int IDX_W  = $clog2(LINES),
   localparam int WORD_W = $clog2(WORDS),
   localparam int DEPTH  = LINES * WORDS
) (
   input  logic              clk,
   input  logic              we,
   input  logic [IDX_W-1:0]  w_idx,
   input  logic [WORD_W-1:0] w_word,
   input  logic [DATA_W-1:0] w_data,
   input  logic [IDX_W-1:0]  ra_idx,
   input  logic [WORD_W-1:0] ra_word,
   output logic [DATA_W-1:0] ra_data,
   input  logic [IDX_W-1:0]  rb_idx,
   input  logic [WORD_W-1:0] rb_word,
   output logic [DATA_W-1:0] rb_data
);
   timeunit 1ns;
   timeprecision 1ps;

   logic [DATA_W-1:0] store_q [DEPTH];

   always_ff @(posedge clk) begin
      if (we) store_q[{w_idx, w_word}] <= w_data;
   end

   // Port A serves the processor, port B feeds write-backs
   assign ra_data = store_q[{ra_idx, ra_word}];
   assign rb_data = store_q[{rb_idx, rb_word}];

endmodule

// File: rtl/dm_cache_ctl.sv
module dm_cache_ctl #(
   parameter int          ADDR_W    = 16,
   parameter int          DATA_W    = 32,
   parameter int          LINES     = 8,
   parameter int          WORDS     = 4,
   parameter int          IO_BITS   = 4,
   parameter int unsigned IO_PREFIX = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              copy_back,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              cpu_ready,
   input  logic              flush_req,
   output logic              flush_done,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_ack
);
   timeunit 1ns;
   timeprecision 1ps;
   import dmc_pkg::*;

   localparam int BYTE_W = $clog2(DATA_W / 8);
   localparam int WORD_W = $clog2(WORDS);
   localparam int IDX_W  = $clog2(LINES);
   localparam int TAG_W  = ADDR_W - IDX_W - WORD_W - BYTE_W;

   // Elaboration-time parameter checks
   if ((LINES < 2) || ((LINES & (LINES - 1)) != 0)) begin : g_bad_lines
      $error("LINES must be a power of two of at least 2");
   end
   if ((WORDS < 2) || ((WORDS & (WORDS - 1)) != 0)) begin : g_bad_words
      $error("WORDS must be a power of two of at least 2");
   end
   if ((DATA_W < 16) || ((DATA_W & (DATA_W - 1)) != 0)) begin : g_bad_data
      $error("DATA_W must be a power of two of at least 16");
   end
   if ((TAG_W < 1) || (IO_BITS > TAG_W)) begin : g_bad_tag
      $error("address too narrow for geometry or uncacheable window");
   end

   // Address fields of the processor request
   logic [WORD_W-1:0] cpu_word;
   logic [IDX_W-1:0]  cpu_idx;
   logic [TAG_W-1:0]  cpu_tag;
   logic              cpu_io;

   assign cpu_word = cpu_addr[BYTE_W +: WORD_W];
   assign cpu_idx  = cpu_addr[BYTE_W + WORD_W +: IDX_W];
   assign cpu_tag  = cpu_addr[ADDR_W-1 -: TAG_W];

   if (IO_BITS > 0) begin : g_io_win
      assign cpu_io = (cpu_addr[ADDR_W-1 -: IO_BITS] == IO_BITS'(IO_PREFIX));
   end else begin : g_no_io_win
      assign cpu_io = 1'b0;
   end

   // State
   dmc_state_e        state_q, state_n;
   logic [WORD_W-1:0] cnt_q, cnt_n;
   logic [IDX_W-1:0]  fl_q, fl_n;
   logic              done_q, done_n;

   logic              flushing;
   logic [IDX_W-1:0]  line_idx;
   logic              line_valid, line_dirty;
   logic [TAG_W-1:0]  line_tag;
   logic              hit, last_word, last_line;

   logic              ts_fill, ts_dirty, ts_clean, ts_inval, ts_inval_all;
   logic              ds_we;
   logic [WORD_W-1:0] ds_word;
   logic [DATA_W-1:0] ds_wdata;
   logic [DATA_W-1:0] hit_data, wb_data;

   assign flushing  = (state_q == ST_FSCAN) || (state_q == ST_FWB);
   assign line_idx  = flushing ? fl_q : cpu_idx;
   assign hit       = line_valid && (line_tag == cpu_tag) && !cpu_io;
   assign last_word = (cnt_q == WORD_W'(WORDS - 1));
   assign last_line = (fl_q == IDX_W'(LINES - 1));

   dmc_tag_store #(
      .LINES (LINES),
      .TAG_W (TAG_W)
   ) u_tags (
      .clk        (clk),
      .rst_n      (rst_n),
      .idx        (line_idx),
      .fill       (ts_fill),
      .fill_tag   (cpu_tag),
      .set_dirty  (ts_dirty),
      .clean      (ts_clean),
      .inval      (ts_inval),
      .inval_all  (ts_inval_all),
      .line_valid (line_valid),
      .line_dirty (line_dirty),
      .line_tag   (line_tag)
   );

   dmc_data_store #(
      .LINES  (LINES),
      .WORDS  (WORDS),
      .DATA_W (DATA_W)
   ) u_data (
      .clk     (clk),
      .we      (ds_we),
      .w_idx   (cpu_idx),
      .w_word  (ds_word),
      .w_data  (ds_wdata),
      .ra_idx  (cpu_idx),
      .ra_word (cpu_word),
      .ra_data (hit_data),
      .rb_idx  (line_idx),
      .rb_word (cnt_q),
      .rb_data (wb_data)
   );

   // Sequencer
   always_comb begin
      state_n      = state_q;
      cnt_n        = cnt_q;
      fl_n         = fl_q;
      done_n       = 1'b0;
      cpu_ready    = 1'b0;
      ts_fill      = 1'b0;
      ts_dirty     = 1'b0;
      ts_clean     = 1'b0;
      ts_inval     = 1'b0;
      ts_inval_all = 1'b0;
      ds_we        = 1'b0;
      ds_word      = cpu_word;
      ds_wdata     = cpu_wdata;
      unique case (state_q)
         ST_IDLE: begin
            if (flush_req) begin
               if (copy_back) begin
                  fl_n    = '0;
                  state_n = ST_FSCAN;
               end else begin
                  ts_inval_all = 1'b1;
                  done_n       = 1'b1;
               end
            end else if (cpu_req) begin
               if (cpu_io) begin
                  state_n = ST_BYP;
               end else if (hit) begin
                  if (!cpu_we) begin
                     cpu_ready = 1'b1;
                  end else if (copy_back) begin
                     cpu_ready = 1'b1;
                     ds_we     = 1'b1;
                     ts_dirty  = 1'b1;
                  end else begin
                     state_n = ST_WT;
                  end
               end else begin
                  cnt_n   = '0;
                  state_n = (copy_back && line_valid && line_dirty) ? ST_EVICT : ST_FILL;
               end
            end
         end
         ST_BYP: begin
            if (mem_ack) begin
               cpu_ready = 1'b1;
               state_n   = ST_IDLE;
            end
         end
         ST_WT: begin
            if (mem_ack) begin
               cpu_ready = 1'b1;
               ds_we     = 1'b1;
               state_n   = ST_IDLE;
            end
         end
         ST_EVICT: begin
            if (mem_ack) begin
               cnt_n = cnt_q + WORD_W'(1);
               if (last_word) state_n = ST_FILL;
            end
         end
         ST_FILL: begin
            if (mem_ack) begin
               ds_we    = 1'b1;
               ds_word  = cnt_q;
               ds_wdata = mem_rdata;
               cnt_n    = cnt_q + WORD_W'(1);
               if (last_word) begin
                  ts_fill = 1'b1;
                  state_n = ST_IDLE;
               end
            end
         end
         ST_FSCAN: begin
            if (line_valid && line_dirty) begin
               cnt_n   = '0;
               state_n = ST_FWB;
            end else begin
               ts_inval = 1'b1;
               if (last_line) begin
                  done_n  = 1'b1;
                  state_n = ST_IDLE;
               end else begin
                  fl_n = fl_q + IDX_W'(1);
               end
            end
         end
         ST_FWB: begin
            if (mem_ack) begin
               cnt_n = cnt_q + WORD_W'(1);
               if (last_word) begin
                  ts_clean = 1'b1;
                  state_n  = ST_FSCAN;
               end
            end
         end
         default: state_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         fl_q    <= '0;
         done_q  <= 1'b0;
      end else begin
         state_q <= state_n;
         cnt_q   <= cnt_n;
         fl_q    <= fl_n;
         done_q  <= done_n;
      end
   end

   assign flush_done = done_q;
   assign cpu_rdata  = (state_q == ST_BYP) ? mem_rdata : hit_data;

   // Memory port, driven from registered state only
   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = '0;
      mem_wdata = '0;
      unique case (state_q)
         ST_BYP: begin
            mem_req   = 1'b1;
            mem_we    = cpu_we;
            mem_addr  = cpu_addr;
            mem_wdata = cpu_wdata;
         end
         ST_WT: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = cpu_addr;
            mem_wdata = cpu_wdata;
         end
         ST_EVICT, ST_FWB: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = {line_tag, line_idx, cnt_q, {BYTE_W{1'b0}}};
            mem_wdata = wb_data;
         end
         ST_FILL: begin
            mem_req  = 1'b1;
            mem_addr = {cpu_tag, cpu_idx, cnt_q, {BYTE_W{1'b0}}};
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/dmc_checker.sv
module dmc_checker #(
   parameter int          ADDR_W    = 16,
   parameter int          DATA_W    = 32,
   parameter int          WORDS     = 4,
   parameter int          IO_BITS   = 4,
   parameter int unsigned IO_PREFIX = 15
) (
   input logic              clk,
   input logic              rst_n,
   input logic              copy_back,
   input logic              cpu_req,
   input logic              cpu_we,
   input logic [ADDR_W-1:0] cpu_addr,
   input logic              cpu_ready,
   input logic              mem_req,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_ack
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam int BYTE_W = $clog2(DATA_W / 8);
   localparam int WORD_W = $clog2(WORDS);

   logic cpu_io, mem_io, mem_last;

   if (IO_BITS > 0) begin : g_io
      assign cpu_io = (cpu_addr[ADDR_W-1 -: IO_BITS] == IO_BITS'(IO_PREFIX));
      assign mem_io = (mem_addr[ADDR_W-1 -: IO_BITS] == IO_BITS'(IO_PREFIX));
   end else begin : g_no_io
      assign cpu_io = 1'b0;
      assign mem_io = 1'b0;
   end

   assign mem_last = (mem_addr[BYTE_W +: WORD_W] == WORD_W'(WORDS - 1));

   // R11: processor completion only inside a request
   a_r11_ready_with_req: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |-> cpu_req);

   // R11: memory request held until acknowledged
   a_r11_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   // R3 / R8: line bursts advance one word at a time
   a_r3_burst_step: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_ack && !mem_io && (!mem_we || copy_back) && !mem_last)
      |=> (mem_req && (mem_addr == $past(mem_addr) + ADDR_W'(DATA_W / 8))));

   // R4: uncached accesses pass straight through
   a_r4_io_direct: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_io) |-> (cpu_req && (mem_addr == cpu_addr) && (mem_we == cpu_we)));

   // R6: a write-through write ends only with its memory write
   a_r6_wt_write: assert property (@(posedge clk) disable iff (!rst_n)
      (!copy_back && cpu_ready && cpu_we && !cpu_io)
      |-> (mem_req && mem_ack && mem_we && (mem_addr == cpu_addr)));

   // R7: a copy-back write completes with the memory port idle
   a_r7_cb_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (copy_back && cpu_ready && cpu_we && !cpu_io) |-> !mem_req);

endmodule

bind dm_cache_ctl dmc_checker #(
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .WORDS     (WORDS),
   .IO_BITS   (IO_BITS),
   .IO_PREFIX (IO_PREFIX)
) u_dmc_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .copy_back (copy_back),
   .cpu_req   (cpu_req),
   .cpu_we    (cpu_we),
   .cpu_addr  (cpu_addr),
   .cpu_ready (cpu_ready),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr),
   .mem_ack   (mem_ack)
);

// File: tb/tb_dm_cache_ctl.sv
module tb_dm_cache_ctl;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int MEM_LAT = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        copy_back = 1'b0;
   logic        cpu_req = 1'b0;
   logic        cpu_we = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic [31:0] cpu_wdata = '0;
   logic [31:0] cpu_rdata;
   logic        cpu_ready;
   logic        flush_req = 1'b0;
   logic        flush_done;
   logic        mem_req;
   logic        mem_we;
   logic [15:0] mem_addr;
   logic [31:0] mem_wdata;
   logic [31:0] mem_rdata = '0;
   logic        mem_ack = 1'b0;

   int checks = 0;
   int fails  = 0;

   // 125 MHz
   always #4 clk = ~clk;

   dm_cache_ctl dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .copy_back  (copy_back),
      .cpu_req    (cpu_req),
      .cpu_we     (cpu_we),
      .cpu_addr   (cpu_addr),
      .cpu_wdata  (cpu_wdata),
      .cpu_rdata  (cpu_rdata),
      .cpu_ready  (cpu_ready),
      .flush_req  (flush_req),
      .flush_done (flush_done),
      .mem_req    (mem_req),
      .mem_we     (mem_we),
      .mem_addr   (mem_addr),
      .mem_wdata  (mem_wdata),
      .mem_rdata  (mem_rdata),
      .mem_ack    (mem_ack)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Memory model (aliased on byte address bits [9:2]) and access log
   logic [31:0] mem     [256];
   logic [31:0] ref_mem [256];
   logic [15:0] log_addr [32];
   logic        log_we   [32];
   int          log_n = 0;
   int          mcnt = 0;
   logic [15:0] st_addr = '0;
   logic        st_we = 1'b0;

   initial begin
      for (int i = 0; i < 256; i++) begin
         mem[i]     = 32'hC0DE_0000 + i;
         ref_mem[i] = 32'hC0DE_0000 + i;
      end
   end

   always @(negedge clk) begin
      if (!rst_n) begin
         mem_ack = 1'b0;
         mcnt    = 0;
      end else if (mem_ack) begin
         mem_ack = 1'b0;
         mcnt    = 0;
      end else if (mem_req) begin
         if (mcnt == 0) begin
            st_addr = mem_addr;
            st_we   = mem_we;
         end
         if (mcnt == MEM_LAT - 1) begin
            // R11: request stayed put while waiting
            chk("R11 addr held", {16'h0, mem_addr}, {16'h0, st_addr});
            chk("R11 dir held", {31'h0, mem_we}, {31'h0, st_we});
            if (mem_we) mem[mem_addr[9:2]] = mem_wdata;
            mem_rdata = mem[mem_addr[9:2]];
            if (log_n < 32) begin
               log_addr[log_n] = mem_addr;
               log_we[log_n]   = mem_we;
            end
            log_n++;
            mem_ack = 1'b1;
         end else begin
            mcnt++;
         end
      end
   end

   task automatic clr_log();
      log_n = 0;
   endtask

   task automatic exp_log(input string req, input int k, input logic [15:0] a, input logic we);
      chk({req, " log addr"}, {16'h0, log_addr[k]}, {16'h0, a});
      chk({req, " log dir"}, {31'h0, log_we[k]}, {31'h0, we});
   endtask

   task automatic do_reset(input logic mode);
      @(negedge clk);
      rst_n     = 1'b0;
      copy_back = mode;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      clr_log();
   endtask

   task automatic acc(input logic we, input logic [15:0] a, input logic [31:0] wd,
                      output logic [31:0] rd, output int cyc);
      @(negedge clk);
      cpu_req   = 1'b1;
      cpu_we    = we;
      cpu_addr  = a;
      cpu_wdata = wd;
      cyc       = 0;
      #1;
      while (!cpu_ready && cyc < 2000) begin
         @(negedge clk);
         #1;
         cyc++;
      end
      rd = cpu_rdata;
      @(negedge clk);
      cpu_req = 1'b0;
      cpu_we  = 1'b0;
      if (we) ref_mem[a[9:2]] = wd;
      if (cyc >= 2000) chk("access timeout", 32'(cyc), 32'd0);
   endtask

   task automatic do_flush(output int cyc);
      @(negedge clk);
      flush_req = 1'b1;
      @(negedge clk);
      flush_req = 1'b0;
      cyc = 1;
      while (!flush_done && cyc < 2000) begin
         @(negedge clk);
         cyc++;
      end
      if (cyc >= 2000) chk("flush timeout", 32'(cyc), 32'd0);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      chk("R1 ready after reset", {31'h0, cpu_ready}, 32'h0);
      chk("R1 mem_req after reset", {31'h0, mem_req}, 32'h0);
      chk("R1 flush_done after reset", {31'h0, flush_done}, 32'h0);
   endtask

   task automatic t_read_fill();
      logic [31:0] rd;
      int cyc;
      clr_log();
      acc(1'b0, 16'h0018, 32'h0, rd, cyc);
      chk("R1 first access misses", 32'(cyc > 0), 32'h1);
      chk("R3 fill count", 32'(log_n), 32'd4);
      for (int k = 0; k < 4; k++) exp_log("R3", k, 16'h0010 + 16'(4 * k), 1'b0);
      chk("R3 miss data", rd, ref_mem[8'h06]);
      acc(1'b0, 16'h0014, 32'h0, rd, cyc);
      chk("R2 hit same cycle", 32'(cyc), 32'd0);
      chk("R2 hit no traffic", 32'(log_n), 32'd4);
      chk("R2 hit data", rd, ref_mem[8'h05]);
   endtask

   task automatic t_uncached();
      logic [31:0] rd;
      int cyc;
      clr_log();
      acc(1'b0, 16'hF020, 32'h0, rd, cyc);
      chk("R4 one access", 32'(log_n), 32'd1);
      exp_log("R4", 0, 16'hF020, 1'b0);
      chk("R4 data", rd, ref_mem[8'h08]);
      acc(1'b0, 16'hF020, 32'h0, rd, cyc);
      chk("R4 no allocation", 32'(log_n), 32'd2);
      acc(1'b1, 16'hF024, 32'h5EED_0001, rd, cyc);
      chk("R4 write one access", 32'(log_n), 32'd3);
      exp_log("R4", 2, 16'hF024, 1'b1);
      acc(1'b0, 16'h0024, 32'h0, rd, cyc);
      chk("R4 cacheable alias fills", 32'(log_n), 32'd7);
      chk("R4 alias data", rd, 32'h5EED_0001);
   endtask

   task automatic t_wt_write();
      logic [31:0] rd;
      int cyc;
      clr_log();
      acc(1'b1, 16'h0018, 32'h1111_2222, rd, cyc);
      chk("R6 one write", 32'(log_n), 32'd1);
      exp_log("R6", 0, 16'h0018, 1'b1);
      chk("R6 memory updated", mem[8'h06], 32'h1111_2222);
      acc(1'b0, 16'h0018, 32'h0, rd, cyc);
      chk("R6 readback hit", 32'(cyc), 32'd0);
      chk("R6 readback data", rd, 32'h1111_2222);
      clr_log();
      acc(1'b1, 16'h0044, 32'h3333_4444, rd, cyc);
      chk("R5 allocate then write", 32'(log_n), 32'd5);
      for (int k = 0; k < 4; k++) exp_log("R5", k, 16'h0040 + 16'(4 * k), 1'b0);
      exp_log("R5", 4, 16'h0044, 1'b1);
      acc(1'b0, 16'h0048, 32'h0, rd, cyc);
      chk("R5 line now hits", 32'(cyc), 32'd0);
      chk("R5 neighbour data", rd, ref_mem[8'h12]);
      acc(1'b0, 16'h0044, 32'h0, rd, cyc);
      chk("R5 written word", rd, 32'h3333_4444);
   endtask

   task automatic t_wt_flush();
      logic [31:0] rd;
      int cyc;
      clr_log();
      do_flush(cyc);
      chk("R9 done next cycle", 32'(cyc), 32'd1);
      chk("R9 no traffic", 32'(log_n), 32'd0);
      acc(1'b0, 16'h0014, 32'h0, rd, cyc);
      chk("R9 line invalid", 32'(log_n), 32'd4);
      chk("R9 refetched data", rd, ref_mem[8'h05]);
   endtask

   task automatic t_cb_write();
      logic [31:0] rd;
      int cyc;
      clr_log();
      acc(1'b1, 16'h0034, 32'hAAAA_0001, rd, cyc);
      chk("R5 cb allocate only reads", 32'(log_n), 32'd4);
      for (int k = 0; k < 4; k++) exp_log("R5 cb", k, 16'h0030 + 16'(4 * k), 1'b0);
      acc(1'b1, 16'h0038, 32'hAAAA_0002, rd, cyc);
      chk("R7 write hit cycle", 32'(cyc), 32'd0);
      chk("R7 no traffic", 32'(log_n), 32'd4);
      chk("R7 memory stale", mem[8'h0E], 32'hC0DE_000E);
      acc(1'b0, 16'h0034, 32'h0, rd, cyc);
      chk("R7 cached value", rd, 32'hAAAA_0001);
   endtask

   task automatic t_cb_evict();
      logic [31:0] rd;
      int cyc;
      clr_log();
      acc(1'b0, 16'h00B4, 32'h0, rd, cyc);
      chk("R8 writeback plus fill", 32'(log_n), 32'd8);
      for (int k = 0; k < 4; k++) exp_log("R8 wb", k, 16'h0030 + 16'(4 * k), 1'b1);
      for (int k = 0; k < 4; k++) exp_log("R8 fill", k + 4, 16'h00B0 + 16'(4 * k), 1'b0);
      chk("R8 memory word 1", mem[8'h0D], 32'hAAAA_0001);
      chk("R8 memory word 2", mem[8'h0E], 32'hAAAA_0002);
      chk("R8 new data", rd, ref_mem[8'h2D]);
      clr_log();
      acc(1'b0, 16'h0030, 32'h0, rd, cyc);
      chk("R8 clean victim", 32'(log_n), 32'd4);
      exp_log("R8 clean", 0, 16'h0030, 1'b0);
      chk("R8 data", rd, ref_mem[8'h0C]);
   endtask

   task automatic t_cb_flush();
      logic [31:0] rd;
      int cyc;
      acc(1'b1, 16'h0028, 32'hBBBB_0001, rd, cyc);
      acc(1'b1, 16'h0050, 32'hBBBB_0002, rd, cyc);
      clr_log();
      do_flush(cyc);
      chk("R10 dirty lines written", 32'(log_n), 32'd8);
      for (int k = 0; k < 4; k++) exp_log("R10 line2", k, 16'h0020 + 16'(4 * k), 1'b1);
      for (int k = 0; k < 4; k++) exp_log("R10 line5", k + 4, 16'h0050 + 16'(4 * k), 1'b1);
      chk("R10 memory line2", mem[8'h0A], 32'hBBBB_0001);
      chk("R10 memory line5", mem[8'h14], 32'hBBBB_0002);
      chk("R10 done pulse", {31'h0, flush_done}, 32'h1);
      clr_log();
      acc(1'b0, 16'h0038, 32'h0, rd, cyc);
      chk("R10 clean line invalid", 32'(log_n), 32'd4);
      chk("R10 data after flush", rd, 32'hAAAA_0002);
      clr_log();
      acc(1'b0, 16'h0054, 32'h0, rd, cyc);
      chk("R10 dirty line invalid", 32'(log_n), 32'd4);
      chk("R10 flushed data", rd, ref_mem[8'h15]);
   endtask

   initial begin
      do_reset(1'b0);
      t_reset();
      t_read_fill();
      t_uncached();
      t_wt_write();
      t_wt_flush();
      do_reset(1'b1);
      t_reset();
      t_cb_write();
      t_cb_evict();
      t_cb_flush();
      repeat (4) @(negedge clk);
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
   end

endmodule